// File: doc/BRIEF.md
# MII Ethernet Frame Transmitter

This block turns a byte stream into Ethernet frames on a 4-bit media-independent transmit interface running at 100 Mbit/s, one nibble per rising edge of the 25 MHz transmit clock. A source offers payload bytes with a valid/ready handshake and marks the final byte of each frame. The block starts the frame with the preamble and start-of-frame delimiter. It then sends each payload byte as two nibbles and closes the frame with a 32-bit frame check sequence that it computes while the payload goes out.

The transmit-enable output stays high for every nibble of a frame, and the data lines are held at zero at all other times. After each frame the block keeps transmit-enable low for a minimum inter-frame gap before it starts the next one. Payload padding, protocol headers and PHY management belong to other blocks.

Top module: `mii_frame_tx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `tx_en` is 0, `txd` is 0 and `in_ready` is 0.
- R2: A frame opens with fifteen nibbles of 0x5 followed by one nibble of 0xD. `tx_en` rises together with the first 0x5 nibble.
- R3: Each payload byte goes out once, in the order accepted, as bits [3:0] followed by bits [7:4] on the next cycle.
- R4: The last eight nibbles of a frame carry the complement of the reflected CRC-32 (polynomial 0xEDB88320, start value 0xFFFFFFFF) over the payload. The value goes out from its least significant nibble upward. For the payload bytes "123456789" the value is 0xCBF43926.
- R5: `tx_en` stays high without a break from the first preamble nibble to the last check nibble, so a frame with N payload bytes lasts 16 + 2N + 8 cycles.
- R6: `txd` is 0 on every cycle on which `tx_en` is 0.
- R7: `in_ready` is high only on the cycle where the next byte's low nibble is due, so at most once every two cycles and only while `tx_en` is high. It is low during the preamble, the check sequence, the gap and idle. A byte is taken when `in_valid` and `in_ready` are both high.
- R8: Between the end of one frame and the start of the next, `tx_en` is low for at least 24 cycles.
- R9: A byte taken with `in_last` high is the final payload byte. If `in_valid` is low when a byte is due, the payload ends there and the check sequence covers only the bytes already sent.
- R10: A frame starts only when `in_valid` is high while the block is idle, and the first accepted byte follows the 0xD nibble directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 25 MHz transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte present |
| in_last | input | 1 | Byte is the last of its frame |
| in_ready | output | 1 | Block takes the byte this cycle |
| txd | output | 4 | Transmit nibble |
| tx_en | output | 1 | Transmit enable |

## Verification
The bench goes after the corners where a transmitter of this kind usually fails. A one-byte frame tests the jump from the delimiter to the check sequence; a nibble-swapped design would show the high nibble first there. The known nine-byte string pins down the CRC polynomial, bit reflection, complement and output order, since any of these being wrong changes the check value. Dropping `in_valid` in the middle of a frame tests the early close, and a design that waited or kept going would stretch the frame or hang. Frames offered back to back show whether the gap is too short, or whether the block leaves residue on `txd` or opens `in_ready` while idle.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_DATA,
        ST_FCS,
        ST_GAP
    } tx_state_e;

    localparam logic [31:0] CRC_POLY   = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED   = 32'hFFFFFFFF;
    localparam logic [3:0]  NIB_PRE    = 4'h5;
    localparam logic [3:0]  NIB_SFD    = 4'hD;
endpackage

// File: rtl/crc32_nib_step.sv
module crc32_nib_step #(
    parameter logic [31:0] POLY = 32'hEDB88320
) (
    input  logic [31:0] crc_i,
    input  logic [3:0]  nib_i,
    output logic [31:0] crc_o
);
    always_comb begin
        logic [31:0] c;
        c = crc_i;
        for (int i = 0; i < 4; i++) begin
            if (c[0] ^ nib_i[i]) c = (c >> 1) ^ POLY;
            else                 c = c >> 1;
        end
        crc_o = c;
    end
endmodule

// File: rtl/fcs_nib_pick.sv
module fcs_nib_pick (
    input  logic [31:0] crc_i,
    input  logic [2:0]  idx_i,
    output logic [3:0]  nib_o
);
    logic [31:0] fcs;
    assign fcs   = ~crc_i;
    assign nib_o = fcs[4*idx_i +: 4];
endmodule

// File: rtl/mii_frame_tx.sv
module mii_frame_tx
    import mii_tx_pkg::*;
#(
    parameter int PRE_NIBBLES = 16,
    parameter int IFG_NIBBLES = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_last,
    output logic       in_ready,
    output logic [3:0] txd,
    output logic       tx_en
);
    localparam int CMAX = (PRE_NIBBLES > IFG_NIBBLES) ? PRE_NIBBLES : IFG_NIBBLES;
    localparam int CW   = $clog2(CMAX + 1);
    localparam int FCS_NIBBLES = 8;

    typedef struct packed {
        tx_state_e   st;
        logic [CW-1:0] cnt;
        logic        phase;
        logic [3:0]  hi;
        logic        last;
        logic [31:0] crc;
        logic [3:0]  txd;
        logic        en;
    } tx_reg_t;

    localparam tx_reg_t RST_V = '{st: ST_IDLE, cnt: '0, phase: 1'b0, hi: 4'h0,
                                  last: 1'b0, crc: CRC_SEED, txd: 4'h0, en: 1'b0};

    tx_reg_t q, d;
    logic [3:0]  step_nib;
    logic [31:0] crc_next;
    logic [2:0]  fcs_idx;
    logic [3:0]  fcs_nib;

    assign step_nib = q.phase ? q.hi : in_data[3:0];
    assign fcs_idx  = (q.st == ST_FCS) ? q.cnt[2:0] : 3'd0;

    crc32_nib_step #(.POLY(CRC_POLY)) u_crc (
        .crc_i (q.crc),
        .nib_i (step_nib),
        .crc_o (crc_next)
    );

    fcs_nib_pick u_fcs (
        .crc_i (q.crc),
        .idx_i (fcs_idx),
        .nib_o (fcs_nib)
    );

    assign in_ready = (q.st == ST_DATA) && !q.phase;
    assign txd      = q.txd;
    assign tx_en    = q.en;

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                d.txd   = 4'h0;
                d.en    = 1'b0;
                d.crc   = CRC_SEED;
                d.phase = 1'b0;
                if (in_valid) begin
                    d.st  = ST_PRE;
                    d.txd = NIB_PRE;
                    d.en  = 1'b1;
                    d.cnt = CW'(1);
                end
            end
            ST_PRE: begin
                d.en  = 1'b1;
                d.cnt = q.cnt + CW'(1);
                if (q.cnt == CW'(PRE_NIBBLES - 1)) begin
                    d.txd = NIB_SFD;
                    d.st  = ST_DATA;
                    d.cnt = '0;
                end else begin
                    d.txd = NIB_PRE;
                end
            end
            ST_DATA: begin
                d.en = 1'b1;
                if (!q.phase) begin
                    if (in_valid) begin
                        d.txd   = in_data[3:0];
                        d.hi    = in_data[7:4];
                        d.last  = in_last;
                        d.crc   = crc_next;
                        d.phase = 1'b1;
                    end else begin
                        d.txd = fcs_nib;
                        d.cnt = CW'(1);
                        d.st  = ST_FCS;
                    end
                end else begin
                    d.txd   = q.hi;
                    d.crc   = crc_next;
                    d.phase = 1'b0;
                    if (q.last) begin
                        d.st  = ST_FCS;
                        d.cnt = '0;
                    end
                end
            end
            ST_FCS: begin
                d.en  = 1'b1;
                d.txd = fcs_nib;
                d.cnt = q.cnt + CW'(1);
                if (q.cnt == CW'(FCS_NIBBLES - 1)) begin
                    d.st  = ST_GAP;
                    d.cnt = '0;
                end
            end
            ST_GAP: begin
                d.en  = 1'b0;
                d.txd = 4'h0;
                d.cnt = q.cnt + CW'(1);
                if (q.cnt == CW'(IFG_NIBBLES - 1)) begin
                    d.st  = ST_IDLE;
                    d.cnt = '0;
                end
            end
            default: d = RST_V;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_V;
        else        q <= d;
    end

    // Run length of low transmit-enable cycles, saturating, for the gap check
    localparam int LW = $clog2(IFG_NIBBLES + 2);
    logic [LW-1:0] low_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                         low_run_q <= LW'(IFG_NIBBLES);
        else if (tx_en)                     low_run_q <= '0;
        else if (low_run_q != LW'(IFG_NIBBLES)) low_run_q <= low_run_q + LW'(1);
    end

    // R6
    txd_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (txd == 4'h0));

    // R7
    ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> tx_en);

    // R7
    single_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R3
    lo_nibble_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (txd == $past(in_data[3:0])));

    // R2
    pre_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (txd == NIB_PRE));

    // R8
    ifg_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (low_run_q >= LW'(IFG_NIBBLES)));
endmodule

// File: tb/mii_frame_tx_bench.sv
module mii_frame_tx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic [3:0] txd;
    logic       tx_en;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mii_frame_tx u_mii_frame_tx (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_last(in_last), .in_ready(in_ready), .txd(txd), .tx_en(tx_en)
    );

    // expected frames, flattened
    byte unsigned exp_bytes[$];
    int           exp_len[$];
    int           frames_done = 0;
    int           idle_bad = 0;
    int           ready_bad = 0;
    int           low_run = 1000;
    bit           in_frame = 0;
    logic [3:0]   nib[$];

    function automatic logic [31:0] ref_fcs(byte unsigned b[$]);
        logic [31:0] c = 32'hFFFFFFFF;
        foreach (b[i]) begin
            c ^= {24'h0, b[i]};
            for (int k = 0; k < 8; k++)
                c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_frame();
        int n = exp_len.pop_front();
        byte unsigned pl[$];
        logic [31:0] got_fcs = '0;
        logic [31:0] want;
        bit pre_ok = 1;
        bit pay_ok = 1;
        for (int i = 0; i < n; i++) pl.push_back(exp_bytes.pop_front());
        want = ref_fcs(pl);
        check(nib.size() == 16 + 2*n + 8, "R5", "frame nibble count", nib.size(), 16 + 2*n + 8);
        if (nib.size() == 16 + 2*n + 8) begin
            for (int i = 0; i < 15; i++) if (nib[i] != 4'h5) pre_ok = 0;
            if (nib[15] != 4'hD) pre_ok = 0;
            check(pre_ok, "R2", "preamble/SFD", {28'h0, nib[15]}, 32'hD);
            for (int j = 0; j < n; j++)
                if ({nib[16+2*j+1], nib[16+2*j]} != pl[j]) pay_ok = 0;
            check(pay_ok, "R3", "payload nibble order", n, n);
            for (int k = 0; k < 8; k++) got_fcs[4*k +: 4] = nib[16 + 2*n + k];
            check(got_fcs == want, "R4", "frame check sequence", got_fcs, want);
            if (frames_done == 0)
                check(got_fcs == 32'hCBF43926, "R4", "known string check value",
                      got_fcs, 32'hCBF43926);
        end
        nib.delete();
        frames_done++;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (in_ready && !tx_en) ready_bad++;
            if (tx_en) begin
                if (!in_frame) begin
                    in_frame = 1;
                    if (frames_done > 0)
                        check(low_run >= 24, "R8", "inter-frame gap", low_run, 24);
                end
                nib.push_back(txd);
                low_run = 0;
            end else begin
                if (txd != 4'h0) idle_bad++;
                if (in_frame) begin
                    in_frame = 0;
                    if (exp_len.size() == 0)
                        check(0, "R10", "unexpected frame", nib.size(), 0);
                    else
                        check_frame();
                end
                low_run++;
            end
        end
    end

    // send n bytes of b; if cut >= 0, drop valid after cut bytes without last
    task automatic send(byte unsigned b[$], int cut);
        int n = (cut >= 0) ? cut : b.size();
        exp_len.push_back(n);
        for (int i = 0; i < n; i++) exp_bytes.push_back(b[i]);
        for (int i = 0; i < n; i++) begin
            in_data  = b[i];
            in_valid = 1'b1;
            in_last  = (cut < 0) && (i == b.size() - 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        if (cut >= 0) repeat (40) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        check(0, "R5", "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        byte unsigned b[$];
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(tx_en == 1'b0 && txd == 4'h0 && in_ready == 1'b0, "R1", "in reset",
              {tx_en, txd, in_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_en == 1'b0 && txd == 4'h0 && in_ready == 1'b0, "R1", "after reset",
              {tx_en, txd, in_ready}, 0);
        // R10: nothing starts without valid
        repeat (30) @(negedge clk);
        check(tx_en == 1'b0 && nib.size() == 0, "R10", "idle without valid", tx_en, 0);
        // R4: known string "123456789"
        b = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        send(b, -1);
        // R9: one-byte frames at the edges of the byte range
        b = '{8'h00};
        send(b, -1);
        b = '{8'hFF};
        send(b, -1);
        // R9: valid drops after three bytes
        b = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5};
        send(b, 3);
        // random frames, back to back
        for (int f = 0; f < 14; f++) begin
            int len = 1 + ($urandom % 30);
            b.delete();
            for (int i = 0; i < len; i++) b.push_back(8'($urandom));
            send(b, -1);
        end
        while (exp_len.size() != 0) @(negedge clk);
        repeat (40) @(negedge clk);
        check(frames_done == 18, "R10", "frames sent", frames_done, 18);
        check(idle_bad == 0, "R6", "txd nonzero while tx_en low", idle_bad, 0);
        check(ready_bad == 0, "R7", "in_ready high outside frame", ready_bad, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule